// File: doc/BRIEF.md
# Reset-time configuration download loader

This block fills the chip's hardware option register from a small non-volatile configuration area every time the device comes out of reset. The area holds 64 bytes, separate from the user program space. While a power-on reset or a brown-out request is active, the loader keeps its option register cleared. It forces every I/O line to input and keeps all pull-up and pull-down resistors switched off. When reset ends, it reads the area one byte at a time over a byte-wide synchronous read port, starting at address 0. It shifts every byte into an internal serial register, least significant bit first.

After the last bit has been shifted, the loader raises a done flag. It then presents the full option vector, decoded flags for the watchdog hardlock, for the alternate oscillator pin as external clock input and for the clock-monitor reset source, and per-pin pull enables. It also releases the pin override. A brown-out request that arrives in the middle of a download throws the partial result away. Once the request ends, the transfer starts again from address 0.

Top module: `cfg_loader`

## Requirements
- R1: While `rst_n` is low or `bor_req` is high, `cfg_done` is 0, `io_force_input` is 1, `cfg_opts` is all zero and every pull enable is 0. No read is issued in the cycle after `bor_req` was high at a clock edge.
- R2: After reset ends, `mem_rd_en` pulses exactly 64 times, with `mem_addr` taking the values 0, 1, … 63 in that order. The read data is taken one cycle after the address (synchronous memory).
- R3: `cfg_done` rises at the 515th rising clock edge counted from the first edge at which no reset is active. That is 3 setup cycles plus 512 shift cycles, with done set at the edge of the last shift.
- R4: After done, bit 8*i+j of `cfg_opts` equals bit j of configuration byte i. Bit 0 of byte 0 is the first bit shifted in.
- R5: Until `cfg_done` is 1, `cfg_opts` reads all zero and `io_force_input` stays 1. Both change in the cycle in which `cfg_done` goes to 1.
- R6: After done, `opt_wdt_hardlock` equals byte 0 bit 0, `opt_osc2_clk` equals byte 0 bit 1 and `opt_clkmon_rst` equals byte 0 bit 2.
- R7: After done, `pull_up_en[p]` equals bit p of the 16-bit word formed by bytes 2 (low) and 3 (high). `pull_dn_en[p]` equals bit p of bytes 4 (low) and 5 (high), but it is forced to 0 when the pull-up of the same pin is set.
- R8: `bor_req` high during a download, including the cycle of the final shift, leaves `cfg_done` at 0 and clears the register. After release, the next download starts again at address 0 and its result holds only the memory content read in that download.
- R9: `bor_req` rising after done clears `cfg_opts`, the flags and the pulls, and sets `io_force_input` back to 1, in the same cycle.
- R10: Once done, no further read is issued and the outputs stay stable while no reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| bor_req | input | 1 | Brown-out reset request, active high, sampled on the clock |
| mem_rd_en | output | 1 | Read strobe to the configuration area |
| mem_addr | output | 6 | Byte address of the read |
| mem_rd_data | input | 8 | Byte returned one cycle after the strobe |
| cfg_opts | output | 512 | Parallel option vector, zero until done |
| cfg_done | output | 1 | Download complete |
| opt_wdt_hardlock | output | 1 | Watchdog hardlock enable |
| opt_osc2_clk | output | 1 | Take the external clock on the second oscillator pin |
| opt_clkmon_rst | output | 1 | External clock monitor acts as a reset source |
| io_force_input | output | 1 | Override that forces every I/O line to input |
| pull_up_en | output | 16 | Per-pin pull-up enable |
| pull_dn_en | output | 16 | Per-pin pull-down enable |

## Verification
The completion of a download and a fresh brown-out request can land on the same clock edge. At that edge the final shift would set done while the request asks for a clear. The bench counts 514 edges after release and raises `bor_req` at the falling edge just before the 515th. After that edge it expects `cfg_done` still at 0 with all outputs quiet. It then requires the following download to restart at address 0 and to deliver only the newly loaded memory content.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    LD_IDLE  = 3'd0,
    LD_FETCH = 3'd1,
    LD_LOAD  = 3'd2,
    LD_SHIFT = 3'd3,
    LD_DONE  = 3'd4
  } ld_state_t;

  localparam int unsigned BITS_PER_BYTE = 8;
  localparam int unsigned SETUP_CYCLES  = 3;

  // edges from reset release to the edge that sets done
  function automatic int unsigned load_cycles(input int unsigned nbytes);
    return SETUP_CYCLES + nbytes * BITS_PER_BYTE;
  endfunction

  // position of configuration byte b, bit j, in the option vector
  function automatic int unsigned opt_bit_pos(input int unsigned b, input int unsigned j);
    return b * BITS_PER_BYTE + j;
  endfunction

  // a pull-down survives only where no pull-up is requested
  function automatic logic pull_down_keep(input logic up, input logic dn);
    return dn & ~up;
  endfunction

endpackage

// File: rtl/cfg_fetch_ctrl.sv
module cfg_fetch_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int unsigned NBYTES = 64,
  localparam int unsigned AW    = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  output logic          load_byte,
  output logic          shift_en,
  output logic [2:0]    bit_sel,
  output logic          done_q,
  output logic          last_shift
);

  localparam logic [AW-1:0] LAST_BYTE = AW'(NBYTES - 1);

  ld_state_t     state;
  logic [AW-1:0] byte_cnt;
  logic [2:0]    bit_cnt;
  logic          fetch_start;
  logic          mid_read;
  logic          byte_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LD_IDLE;
      byte_cnt <= '0;
      bit_cnt  <= '0;
      done_q   <= 1'b0;
    end else if (hold) begin
      state    <= LD_IDLE;
      byte_cnt <= '0;
      bit_cnt  <= '0;
      done_q   <= 1'b0;
    end else begin
      unique case (state)
        LD_IDLE:  state <= LD_FETCH;
        LD_FETCH: state <= LD_LOAD;
        LD_LOAD: begin
          state    <= LD_SHIFT;
          bit_cnt  <= '0;
          byte_cnt <= '0;
        end
        LD_SHIFT: begin
          bit_cnt <= bit_cnt + 3'd1;
          if (last_shift) begin
            state  <= LD_DONE;
            done_q <= 1'b1;
          end else if (byte_end) begin
            byte_cnt <= byte_cnt + AW'(1);
          end
        end
        default: state <= LD_DONE;
      endcase
    end
  end

  assign fetch_start = (state == LD_FETCH);
  assign byte_end    = (state == LD_SHIFT) && (bit_cnt == 3'd7);
  assign last_shift  = byte_end && (byte_cnt == LAST_BYTE);
  assign mid_read    = (state == LD_SHIFT) && (bit_cnt == 3'd6) && (byte_cnt != LAST_BYTE);

  assign mem_rd_en = fetch_start | mid_read;
  assign mem_addr  = fetch_start ? '0 : byte_cnt + AW'(1);
  assign load_byte = (state == LD_LOAD) | (byte_end && !last_shift);
  assign shift_en  = (state == LD_SHIFT);
  assign bit_sel   = bit_cnt;

  assert_hold_blocks_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !mem_rd_en);

  assert_last_shift_sets_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_shift && !hold) |=> done_q);

  assert_hold_clears_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !done_q);

endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int unsigned OPT_W = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_byte,
  input  logic [7:0]       rd_data,
  input  logic             shift_en,
  input  logic [2:0]       bit_sel,
  output logic [OPT_W-1:0] sreg
);

  logic [7:0] byte_buf;
  logic       serial_bit;

  assign serial_bit = byte_buf[bit_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_buf <= '0;
      sreg     <= '0;
    end else if (clear) begin
      byte_buf <= '0;
      sreg     <= '0;
    end else begin
      if (load_byte) byte_buf <= rd_data;
      if (shift_en)  sreg     <= {serial_bit, sreg[OPT_W-1:1]};
    end
  end

  assert_clear_empties_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sreg == '0));

endmodule

// File: rtl/cfg_opt_decode.sv
module cfg_opt_decode
  import cfg_loader_pkg::*;
#(
  parameter int unsigned OPT_W   = 512,
  parameter int unsigned NPIN    = 16,
  parameter int unsigned PU_BYTE = 2,
  parameter int unsigned PD_BYTE = 4
) (
  input  logic             done_q,
  input  logic             hold,
  input  logic [OPT_W-1:0] sreg,
  output logic [OPT_W-1:0] cfg_opts,
  output logic             cfg_done,
  output logic             io_force_input,
  output logic             opt_wdt_hardlock,
  output logic             opt_osc2_clk,
  output logic             opt_clkmon_rst,
  output logic [NPIN-1:0]  pull_up_en,
  output logic [NPIN-1:0]  pull_dn_en
);

  logic live;

  assign live           = done_q & ~hold;
  assign cfg_done       = live;
  assign io_force_input = ~live;
  assign cfg_opts       = live ? sreg : '0;

  assign opt_wdt_hardlock = cfg_opts[opt_bit_pos(0, 0)];
  assign opt_osc2_clk     = cfg_opts[opt_bit_pos(0, 1)];
  assign opt_clkmon_rst   = cfg_opts[opt_bit_pos(0, 2)];

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic up_raw, dn_raw;
    assign up_raw        = cfg_opts[opt_bit_pos(PU_BYTE, p)];
    assign dn_raw        = cfg_opts[opt_bit_pos(PD_BYTE, p)];
    assign pull_up_en[p] = up_raw;
    assign pull_dn_en[p] = pull_down_keep(up_raw, dn_raw);
  end

  always_comb begin
    assert_pull_exclusive_R7: assert ((pull_up_en & pull_dn_en) == '0);
  end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned NBYTES  = 64,
  parameter int unsigned NPIN    = 16,
  parameter int unsigned PU_BYTE = 2,
  parameter int unsigned PD_BYTE = 4,
  localparam int unsigned AW     = $clog2(NBYTES),
  localparam int unsigned OPT_W  = NBYTES * BITS_PER_BYTE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bor_req,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_addr,
  input  logic [7:0]       mem_rd_data,
  output logic [OPT_W-1:0] cfg_opts,
  output logic             cfg_done,
  output logic             opt_wdt_hardlock,
  output logic             opt_osc2_clk,
  output logic             opt_clkmon_rst,
  output logic             io_force_input,
  output logic [NPIN-1:0]  pull_up_en,
  output logic [NPIN-1:0]  pull_dn_en
);

  localparam int unsigned LOAD_CYC = load_cycles(NBYTES);
  localparam int unsigned CW       = $clog2(LOAD_CYC + 2);

  logic             load_byte;
  logic             shift_en;
  logic [2:0]       bit_sel;
  logic             done_q;
  logic             last_shift;
  logic [OPT_W-1:0] sreg;

  cfg_fetch_ctrl #(.NBYTES(NBYTES)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (bor_req),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .load_byte  (load_byte),
    .shift_en   (shift_en),
    .bit_sel    (bit_sel),
    .done_q     (done_q),
    .last_shift (last_shift)
  );

  cfg_shift_reg #(.OPT_W(OPT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (bor_req),
    .load_byte (load_byte),
    .rd_data   (mem_rd_data),
    .shift_en  (shift_en),
    .bit_sel   (bit_sel),
    .sreg      (sreg)
  );

  cfg_opt_decode #(
    .OPT_W   (OPT_W),
    .NPIN    (NPIN),
    .PU_BYTE (PU_BYTE),
    .PD_BYTE (PD_BYTE)
  ) u_decode (
    .done_q           (done_q),
    .hold             (bor_req),
    .sreg             (sreg),
    .cfg_opts         (cfg_opts),
    .cfg_done         (cfg_done),
    .io_force_input   (io_force_input),
    .opt_wdt_hardlock (opt_wdt_hardlock),
    .opt_osc2_clk     (opt_osc2_clk),
    .opt_clkmon_rst   (opt_clkmon_rst),
    .pull_up_en       (pull_up_en),
    .pull_dn_en       (pull_dn_en)
  );

  // checker state: reads and cycles since the last reset
  logic [AW:0]   rd_count;
  logic [CW-1:0] cyc_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_count  <= '0;
      cyc_count <= '0;
    end else if (bor_req) begin
      rd_count  <= '0;
      cyc_count <= '0;
    end else begin
      if (mem_rd_en) rd_count <= rd_count + (AW+1)'(1);
      if (!done_q)   cyc_count <= cyc_count + CW'(1);
    end
  end

  assert_addr_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !bor_req) |-> (mem_addr == rd_count[AW-1:0]));

  assert_read_total_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> (rd_count == (AW+1)'(NBYTES)));

  assert_done_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (cyc_count == CW'(LOAD_CYC)));

  assert_opts_quiet_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (cfg_opts == '0 && io_force_input));

  assert_no_read_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !mem_rd_en);

endmodule

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
module cfg_loader_bench;

  localparam int NBYTES  = 64;
  localparam int NPIN    = 16;
  localparam int PU_BYTE = 2;
  localparam int PD_BYTE = 4;
  localparam int AW      = 6;
  localparam int OPT_W   = NBYTES * 8;
  localparam int EDGES_TO_DONE = 3 + NBYTES * 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bor_req;
  logic             mem_rd_en;
  logic [AW-1:0]    mem_addr;
  logic [7:0]       mem_rd_data;
  logic [OPT_W-1:0] cfg_opts;
  logic             cfg_done;
  logic             opt_wdt_hardlock, opt_osc2_clk, opt_clkmon_rst;
  logic             io_force_input;
  logic [NPIN-1:0]  pull_up_en, pull_dn_en;

  always #10 clk = ~clk;

  cfg_loader u_cfg_loader (
    .clk(clk), .rst_n(rst_n), .bor_req(bor_req),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .cfg_opts(cfg_opts), .cfg_done(cfg_done),
    .opt_wdt_hardlock(opt_wdt_hardlock), .opt_osc2_clk(opt_osc2_clk),
    .opt_clkmon_rst(opt_clkmon_rst), .io_force_input(io_force_input),
    .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en)
  );

  // synchronous configuration memory model
  logic [7:0] rom [NBYTES];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= rom[mem_addr];

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [AW-1:0] addr_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill_rom(input int seed, input logic [7:0] b0);
    for (int i = 0; i < NBYTES; i++)
      rom[i] = 8'((i * 29 + seed * 71 + 5) ^ (i >> 1) ^ (seed << 4));
    rom[0] = b0;
  endtask

  // driver side of the scoreboard: expected read addresses
  task automatic expect_reads();
    addr_q.delete();
    for (int i = 0; i < NBYTES; i++) addr_q.push_back(AW'(i));
  endtask

  // monitor side: every read must match the next expected address
  always @(negedge clk) begin
    if (rst_n === 1'b1 && mem_rd_en === 1'b1) begin
      if (addr_q.size() == 0) chk(1'b0, "R10 read after download", 32'(mem_addr), 32'hFFFF);
      else begin
        automatic logic [AW-1:0] e = addr_q.pop_front();
        chk(mem_addr == e, "R2 read address order", 32'(mem_addr), 32'(e));
      end
    end
  end

  task automatic check_quiet(input string tag);
    chk(cfg_done == 1'b0, {tag, " done low"}, 32'(cfg_done), 0);
    chk(io_force_input == 1'b1, {tag, " pins forced to input"}, 32'(io_force_input), 1);
    chk(cfg_opts == '0, {tag, " options zero"}, 32'(cfg_opts[31:0]), 0);
    chk(pull_up_en == '0 && pull_dn_en == '0, {tag, " pulls off"}, 32'({pull_up_en, pull_dn_en}), 0);
  endtask

  task automatic check_result(input string tag);
    logic [15:0] pu, pd;
    for (int i = 0; i < NBYTES; i++)
      chk(cfg_opts[8*i +: 8] == rom[i], {tag, " R4 option byte"}, 32'(cfg_opts[8*i +: 8]), 32'(rom[i]));
    chk({opt_clkmon_rst, opt_osc2_clk, opt_wdt_hardlock} == rom[0][2:0], {tag, " R6 flags"},
        32'({opt_clkmon_rst, opt_osc2_clk, opt_wdt_hardlock}), 32'(rom[0][2:0]));
    pu = {rom[PU_BYTE+1], rom[PU_BYTE]};
    pd = {rom[PD_BYTE+1], rom[PD_BYTE]} & ~pu;
    chk(pull_up_en == pu, {tag, " R7 pull-up"}, 32'(pull_up_en), 32'(pu));
    chk(pull_dn_en == pd, {tag, " R7 pull-down"}, 32'(pull_dn_en), 32'(pd));
    chk(io_force_input == 1'b0, {tag, " R5 pin release"}, 32'(io_force_input), 0);
  endtask

  // release already done at a falling edge; walk to the done edge
  task automatic run_to_done(input string tag);
    repeat (EDGES_TO_DONE - 1) @(posedge clk);
    @(negedge clk);
    chk(cfg_done == 1'b0, {tag, " R3 done not before edge 515"}, 32'(cfg_done), 0);
    chk(cfg_opts == '0 && io_force_input, {tag, " R5 quiet before done"}, 32'(cfg_opts[31:0]), 0);
    @(posedge clk);
    @(negedge clk);
    chk(cfg_done == 1'b1, {tag, " R3 done at edge 515"}, 32'(cfg_done), 1);
    chk(addr_q.size() == 0, {tag, " R2 all reads issued"}, 32'(addr_q.size()), 0);
  endtask

  initial begin
    logic [OPT_W-1:0] snap;
    rst_n = 1'b0;
    bor_req = 1'b0;
    fill_rom(1, 8'h05);
    expect_reads();
    repeat (3) @(negedge clk);
    check_quiet("R1 power-on reset");

    // first download
    rst_n = 1'b1;
    run_to_done("load1");
    check_result("load1");

    // R10: nothing changes once done
    snap = cfg_opts;
    repeat (30) @(negedge clk);
    chk(cfg_opts == snap && cfg_done, "R10 stable after done", 32'(cfg_opts[31:0]), 32'(snap[31:0]));

    // R9: brown-out after done clears at once
    bor_req = 1'b1;
    #1;
    check_quiet("R9 brown-out after done");
    @(negedge clk);
    check_quiet("R1 brown-out held");

    // R8: abort mid-download, new content after restart
    fill_rom(2, 8'h03);
    expect_reads();
    bor_req = 1'b0;
    repeat (200) @(negedge clk);
    bor_req = 1'b1;
    repeat (2) @(negedge clk);
    check_quiet("R8 abort");
    fill_rom(3, 8'h02);
    expect_reads();
    bor_req = 1'b0;
    run_to_done("R8 restart");
    check_result("R8 restart");

    // R8: request in the same cycle as the final shift
    bor_req = 1'b1;
    @(negedge clk);
    fill_rom(4, 8'h06);
    expect_reads();
    bor_req = 1'b0;
    repeat (EDGES_TO_DONE - 1) @(posedge clk);
    @(negedge clk);
    bor_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_quiet("R8 request on final shift");
    fill_rom(5, 8'h07);
    expect_reads();
    bor_req = 1'b0;
    run_to_done("R8 after collision");
    check_result("R8 after collision");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule